// File: doc/BRIEF.md
# Dual-Threshold Zero Suppression Filter

This block thins out the baseline-corrected samples of one accepted event. Samples arrive one per transfer on a valid/ready stream. They are ordered by channel, and inside each channel by time index, from 0 to `N_T-1`. The block keeps its own channel and time counters, so no position information enters with the data. A run of consecutive samples that lie above a low threshold forms a candidate cluster. The cluster is forwarded only if at least one of its samples also lies above a high threshold. Isolated noise that never reaches the high level is discarded, and the quiet samples around a real pulse are cut down to a short guard band.

A kept cluster is widened by a programmable number of leading and trailing guard samples. It leaves the block as a header word followed by its samples in time order. The header holds the channel number, the time index of the first sample sent and the number of samples sent, so a later stage can place every sample back on the channel/time grid. After the last sample of the last channel the block sends one end-of-event word and starts again at channel 0.

The candidate run is held in a short sample window of `PRE_MAX+MAX_RUN+1` entries until its keep-or-drop decision is known. While the window is replayed the input stalls. The trailing guard samples are then passed straight from input to output.

Top module: `zs_filter`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high, and the first sample accepted is taken as channel 0, time 0.
- R2: A sample counts as above the low level only when it is strictly greater than `thr_lo`, and as above the high level only when it is strictly greater than `thr_hi`; both comparisons are two's-complement signed. A run of consecutive above-low samples is forwarded only when one of its samples is above the high level; a run whose peak equals `thr_hi` is dropped.
- R3: A kept cluster starts `pre_cnt` samples before its run. The start is clipped so that it never goes before time 0 of the channel and never reaches back into the samples already sent for the previous kept cluster of that channel.
- R4: A kept cluster extends `post_cnt` samples past its run, clipped at time `N_T-1`. Those trailing samples are forwarded whatever their value. Detection of a new run resumes only with the sample after them.
- R5: A header word has `out_kind` = 1. `out_data` holds the cluster length (samples that follow) in bits [LW-1:0], the first time index in the next TW bits, and the channel number in the CHW bits above those. LW, TW and CHW are the bit widths needed for `PRE_MAX+MAX_RUN+POST_MAX`, `N_T-1` and `N_CH-1`, and the unused upper bits are zero.
- R6: Each header is followed by exactly its length of sample words, `out_kind` = 2, each carrying the input sample sign-extended to the output width, in increasing time order.
- R7: A run still open at time `N_T-1` is closed there. A run never continues into the next channel, even if the next channel starts above the low level.
- R8: A run that reaches `MAX_RUN` samples is closed at once and kept or dropped by the R2 rule. The next above-low sample starts a new run.
- R9: A channel without a kept cluster produces no words. After the last channel the block sends one word with `out_kind` = 3 and `out_data` = 0.
- R10: While `out_valid` is high and `out_ready` low, `out_kind` and `out_data` hold their values, provided the upstream source holds its sample.
- R11: While a header, a replayed sample or the end-of-event word is offered, `in_ready` is low. Input is taken only on a valid/ready transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_lo | input | SAMPLE_W | Low threshold, signed |
| thr_hi | input | SAMPLE_W | High threshold, signed |
| pre_cnt | input | clog2(PRE_MAX+1) | Leading guard samples per cluster |
| post_cnt | input | clog2(POST_MAX+1) | Trailing guard samples per cluster |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with `in_valid` |
| in_sample | input | SAMPLE_W | Baseline-corrected sample, signed |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_kind | output | 2 | 1 header, 2 sample, 3 end of event |
| out_data | output | max(CHW+TW+LW, SAMPLE_W) | Header fields or sign-extended sample |

## Verification
The bench builds the filter with 4 channels of 32 samples, a 6-sample run limit, and at most 3 leading and 3 trailing guard samples. With 32 samples per channel, every channel edge (clipped guards, a run open at the last sample, a run that meets the next channel) can be hit with only a few pulses. With a 6-sample limit, forced closures and runs that fall just short of the limit both fit easily inside one channel. The bench builds each expected word stream from a per-channel software model. Some events are replayed with input gaps and output back-pressure, which exercises the stall and pass-through paths.

// File: rtl/zs_pkg.sv
package zs_pkg;

    typedef enum logic [1:0] {
        S_SCAN = 2'd0,
        S_EMIT = 2'd1,
        S_POST = 2'd2,
        S_MARK = 2'd3
    } zs_state_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_HDR  = 2'd1,
        K_SMP  = 2'd2,
        K_END  = 2'd3
    } zs_kind_e;

endpackage

// File: rtl/zs_thresh.sv
// Signed comparison of one sample against both levels.
module zs_thresh #(
    parameter int W = 12
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] thr_lo,
    input  logic [W-1:0] thr_hi,
    output logic         above_lo,
    output logic         above_hi
);
    assign above_lo = $signed(sample) > $signed(thr_lo);
    assign above_hi = $signed(sample) > $signed(thr_hi);
endmodule

// File: rtl/zs_span.sv
// Guard-band clipping: leading guard against the free point, trailing guard
// against the end of the channel window.
module zs_span #(
    parameter int N_T      = 160,
    parameter int PRE_MAX  = 4,
    parameter int POST_MAX = 4,
    parameter int TW       = 8,
    parameter int PW       = 3,
    parameter int QW       = 3
) (
    input  logic [TW-1:0] t_now,
    input  logic [TW-1:0] t_free,
    input  logic [TW-1:0] t_end,
    input  logic [PW-1:0] pre_cnt,
    input  logic [QW-1:0] post_cnt,
    output logic [PW-1:0] pre_now,
    output logic [QW-1:0] post_now
);
    int gap_lo, gap_hi, pre_lim, post_lim;

    always_comb begin
        gap_lo   = int'(t_now) - int'(t_free);
        pre_lim  = (int'(pre_cnt) < PRE_MAX) ? int'(pre_cnt) : PRE_MAX;
        pre_now  = PW'((gap_lo < pre_lim) ? gap_lo : pre_lim);
        gap_hi   = (N_T - 1) - int'(t_end);
        post_lim = (int'(post_cnt) < POST_MAX) ? int'(post_cnt) : POST_MAX;
        post_now = QW'((gap_hi < post_lim) ? gap_hi : post_lim);
    end
endmodule

// File: rtl/zs_window.sv
// Shift window holding the most recent samples; index 0 is the newest.
module zs_window #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] win_q   [DEPTH];
    logic [W-1:0] win_d   [DEPTH];
    logic [W-1:0] stage_in[DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage_in[i] = din;
        end else begin : g_tail
            assign stage_in[i] = win_q[i-1];
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            win_d[i] = shift_en ? stage_in[i] : win_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) win_q[i] <= '0;
            else        win_q[i] <= win_d[i];
        end
    end

    assign rd_data = win_q[rd_idx];
endmodule

// File: rtl/zs_filter.sv
module zs_filter
    import zs_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int N_CH     = 64,
    parameter int N_T      = 160,
    parameter int MAX_RUN  = 16,
    parameter int PRE_MAX  = 4,
    parameter int POST_MAX = 4,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int TW  = $clog2(N_T),
    localparam int LW  = $clog2(PRE_MAX + MAX_RUN + POST_MAX + 1),
    localparam int PW  = $clog2(PRE_MAX + 1),
    localparam int QW  = $clog2(POST_MAX + 1),
    localparam int HW  = CHW + TW + LW,
    localparam int DW  = (HW > SAMPLE_W) ? HW : SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] thr_lo,
    input  logic [SAMPLE_W-1:0] thr_hi,
    input  logic [PW-1:0]       pre_cnt,
    input  logic [QW-1:0]       post_cnt,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [1:0]          out_kind,
    output logic [DW-1:0]       out_data
);
    localparam int DEPTH = PRE_MAX + MAX_RUN + 1;
    localparam int IW    = $clog2(DEPTH);
    localparam int RW    = $clog2(MAX_RUN + 1);

    typedef struct packed {
        zs_state_e      st;
        logic [CHW-1:0] ch;
        logic [TW-1:0]  t;
        logic [TW-1:0]  t_free;
        logic [TW-1:0]  start_t;
        logic           in_run;
        logic           hit;
        logic           hdr_pend;
        logic           eoe;
        logic [RW-1:0]  run_len;
        logic [PW-1:0]  pre_eff;
        logic [IW-1:0]  rd_ptr;
        logic [IW-1:0]  rd_end;
        logic [QW-1:0]  post_rem;
        logic [LW-1:0]  hdr_len;
        logic [CHW-1:0] hdr_ch;
        logic [TW-1:0]  hdr_t;
    } ctl_t;

    ctl_t q, d;

    logic                above_lo, above_hi;
    logic [PW-1:0]       pre_now;
    logic [QW-1:0]       post_now;
    logic [TW-1:0]       t_end;
    logic                last_t, last_ch;
    logic                incl_close, excl_close, cl_hit, inc;
    int                  c_len, cl_len, cl_pre, nb, base;
    logic                c_hit;
    logic [PW-1:0]       c_pre;
    logic [TW-1:0]       c_start, cl_start;
    logic                shift_en, adv;
    logic [SAMPLE_W-1:0] rd_data;
    logic [DW-1:0]       ext_in, ext_buf;

    zs_thresh #(.W(SAMPLE_W)) u_thresh (
        .sample   (in_sample),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .above_lo (above_lo),
        .above_hi (above_hi)
    );

    zs_span #(
        .N_T(N_T), .PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX),
        .TW(TW), .PW(PW), .QW(QW)
    ) u_span (
        .t_now    (q.t),
        .t_free   (q.t_free),
        .t_end    (t_end),
        .pre_cnt  (pre_cnt),
        .post_cnt (post_cnt),
        .pre_now  (pre_now),
        .post_now (post_now)
    );

    zs_window #(.W(SAMPLE_W), .DEPTH(DEPTH), .IW(IW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (in_sample),
        .rd_idx   (q.rd_ptr),
        .rd_data  (rd_data)
    );

    // Run bookkeeping for the sample currently on the input.
    always_comb begin
        last_t     = (q.t == TW'(N_T - 1));
        last_ch    = (q.ch == CHW'(N_CH - 1));
        c_len      = q.in_run ? int'(q.run_len) + 1 : 1;
        c_hit      = (q.in_run & q.hit) | above_hi;
        c_pre      = q.in_run ? q.pre_eff : pre_now;
        c_start    = q.in_run ? q.start_t : q.t - TW'(pre_now);
        incl_close = above_lo && (last_t || c_len == MAX_RUN);
        excl_close = q.in_run && !above_lo;
        t_end      = excl_close ? q.t - TW'(1) : q.t;
        cl_len     = excl_close ? int'(q.run_len) : c_len;
        cl_hit     = excl_close ? q.hit : c_hit;
        cl_pre     = excl_close ? int'(q.pre_eff) : int'(c_pre);
        cl_start   = excl_close ? q.start_t : c_start;
        inc        = excl_close && (post_now != '0);
        base       = (excl_close && post_now == '0) ? 1 : 0;
        nb         = cl_pre + cl_len + (inc ? 1 : 0);
        ext_in     = DW'($signed(in_sample));
        ext_buf    = DW'($signed(rd_data));
    end

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_kind  = K_SMP;
        out_data  = '0;
        shift_en  = 1'b0;
        adv       = 1'b0;

        case (q.st)
            S_SCAN: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    shift_en = 1'b1;
                    adv      = 1'b1;
                    if (incl_close || excl_close) begin
                        d.in_run = 1'b0;
                        if (cl_hit) begin
                            d.st       = S_EMIT;
                            d.hdr_pend = 1'b1;
                            d.rd_ptr   = IW'(base + nb - 1);
                            d.rd_end   = IW'(base);
                            d.post_rem = post_now - QW'(inc);
                            d.hdr_len  = LW'(cl_pre + cl_len + int'(post_now));
                            d.hdr_ch   = q.ch;
                            d.hdr_t    = cl_start;
                            d.t_free   = TW'(int'(t_end) + int'(post_now) + 1);
                        end
                    end else if (above_lo) begin
                        d.in_run  = 1'b1;
                        d.run_len = RW'(c_len);
                        d.hit     = c_hit;
                        d.pre_eff = c_pre;
                        d.start_t = c_start;
                    end
                end
            end
            S_EMIT: begin
                out_valid = 1'b1;
                if (q.hdr_pend) begin
                    out_kind = K_HDR;
                    out_data = DW'({q.hdr_ch, q.hdr_t, q.hdr_len});
                    if (out_ready) d.hdr_pend = 1'b0;
                end else begin
                    out_kind = K_SMP;
                    out_data = ext_buf;
                    if (out_ready) begin
                        if (q.rd_ptr == q.rd_end) begin
                            if (q.post_rem != '0) d.st = S_POST;
                            else if (q.eoe)       d.st = S_MARK;
                            else                  d.st = S_SCAN;
                        end else begin
                            d.rd_ptr = q.rd_ptr - IW'(1);
                        end
                    end
                end
            end
            S_POST: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_kind  = K_SMP;
                out_data  = ext_in;
                if (in_valid && out_ready) begin
                    shift_en   = 1'b1;
                    adv        = 1'b1;
                    d.post_rem = q.post_rem - QW'(1);
                    if (q.post_rem == QW'(1)) d.st = S_SCAN;
                end
            end
            default: begin
                out_valid = 1'b1;
                out_kind  = K_END;
                if (out_ready) begin
                    d.st  = S_SCAN;
                    d.eoe = 1'b0;
                end
            end
        endcase

        // Channel and time position of the stream.
        if (adv && last_t) begin
            d.t      = '0;
            d.t_free = '0;
            d.in_run = 1'b0;
            if (last_ch) begin
                d.ch  = '0;
                d.eoe = 1'b1;
                if (d.st == S_SCAN) d.st = S_MARK;
            end else begin
                d.ch = q.ch + CHW'(1);
            end
        end else if (adv) begin
            d.t = q.t + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/zs_filter_chk.sv
module zs_filter_chk
    import zs_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int N_CH     = 64,
    parameter int N_T      = 160,
    parameter int MAX_RUN  = 16,
    parameter int PRE_MAX  = 4,
    parameter int POST_MAX = 4,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int TW  = $clog2(N_T),
    localparam int LW  = $clog2(PRE_MAX + MAX_RUN + POST_MAX + 1),
    localparam int HW  = CHW + TW + LW,
    localparam int DW  = (HW > SAMPLE_W) ? HW : SAMPLE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [1:0]    out_kind,
    input logic [DW-1:0] out_data
);
    logic [LW-1:0] f_len;
    logic [TW-1:0] f_t;
    assign f_len = out_data[LW-1:0];
    assign f_t   = out_data[LW+TW-1:LW];

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && in_valid |=> out_valid && $stable(out_kind) && $stable(out_data));

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_kind == K_HDR || out_kind == K_END) |-> !in_ready);

    p_end_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == K_END |-> out_data == '0);

    p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == K_HDR |->
            f_len != '0 && int'(f_len) <= PRE_MAX + MAX_RUN + POST_MAX);

    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == K_HDR |-> int'(f_t) + int'(f_len) <= N_T);

    p_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_kind != K_NONE);
endmodule

bind zs_filter zs_filter_chk #(
    .SAMPLE_W(SAMPLE_W), .N_CH(N_CH), .N_T(N_T),
    .MAX_RUN(MAX_RUN), .PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_data(out_data)
);

// File: tb/zs_filter_bench.sv
module zs_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW   = 10;
    localparam int NCH  = 4;
    localparam int NT   = 32;
    localparam int MR   = 6;
    localparam int PMX  = 3;
    localparam int QMX  = 3;
    localparam int CHW  = 2;
    localparam int TW   = 5;
    localparam int LW   = 4;
    localparam int DW   = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0] thr_lo = '0, thr_hi = '0;
    logic [1:0] pre_cnt = '0, post_cnt = '0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic in_ready, out_valid;
    logic [1:0] out_kind;
    logic [DW-1:0] out_data;

    int checks = 0, fails = 0;
    logic signed [SW-1:0] ev [NCH][NT];
    logic [1:0]    exp_k[$];
    logic [DW-1:0] exp_d[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    zs_filter #(.SAMPLE_W(SW), .N_CH(NCH), .N_T(NT), .MAX_RUN(MR),
                .PRE_MAX(PMX), .POST_MAX(QMX)) u_zs_filter (
        .clk(clk), .rst_n(rst_n), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .pre_cnt(pre_cnt), .post_cnt(post_cnt), .in_valid(in_valid),
        .in_ready(in_ready), .in_sample(in_sample), .out_valid(out_valid),
        .out_ready(out_ready), .out_kind(out_kind), .out_data(out_data));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_event();
        for (int c = 0; c < NCH; c++)
            for (int t = 0; t < NT; t++) ev[c][t] = '0;
    endtask

    // Expected stream built per channel from the requirements.
    task automatic build_expected(input int lo, input int hi, input int pre, input int post);
        exp_k.delete(); exp_d.delete();
        for (int c = 0; c < NCH; c++) begin
            int t = 0, tfree = 0;
            while (t < NT) begin
                if (int'(ev[c][t]) > lo) begin
                    int start = t, rl = 0, pe, tend, po;
                    bit h = 0;
                    pe = (pre < t - tfree) ? pre : t - tfree;
                    while (t < NT && int'(ev[c][t]) > lo && rl < MR) begin
                        if (int'(ev[c][t]) > hi) h = 1;
                        rl++; t++;
                    end
                    tend = start + rl - 1;
                    po = (post < NT - 1 - tend) ? post : NT - 1 - tend;
                    if (h) begin
                        exp_k.push_back(2'd1);
                        exp_d.push_back(DW'((c << (TW + LW)) | ((start - pe) << LW) | (pe + rl + po)));
                        for (int k = start - pe; k <= tend + po; k++) begin
                            logic signed [DW-1:0] sx;
                            sx = DW'(ev[c][k]);
                            exp_k.push_back(2'd2);
                            exp_d.push_back(sx);
                        end
                        tfree = tend + po + 1;
                        t = tfree;
                    end
                end else begin
                    t++;
                end
            end
        end
        exp_k.push_back(2'd3);
        exp_d.push_back('0);
    endtask

    task automatic run_event(input string req, input int lo, input int hi,
                             input int pre, input int post,
                             input bit in_gaps, input bit out_stall);
        int idx = 0, got = 0, cyc = 0;
        bit done = 0, hold = 0;
        thr_lo = SW'(lo); thr_hi = SW'(hi);
        pre_cnt = 2'(pre); post_cnt = 2'(post);
        build_expected(lo, hi, pre, post);
        while (!done && cyc < 20000) begin
            @(negedge clk);
            in_valid  = hold || ((idx < NCH*NT) && !(in_gaps && (cyc % 3 == 1)));
            in_sample = (idx < NCH*NT) ? ev[idx / NT][idx % NT] : '0;
            out_ready = !(out_stall && (cyc % 4 < 2));
            #1;
            hold = in_valid && !in_ready;
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready) begin
                if (got < exp_k.size()) begin
                    chk(out_kind == exp_k[got], req, $sformatf("kind of word %0d", got),
                        int'(out_kind), int'(exp_k[got]));
                    chk(out_data == exp_d[got], req, $sformatf("data of word %0d", got),
                        int'(out_data), int'(exp_d[got]));
                end else begin
                    chk(0, req, "unexpected extra word", got, exp_k.size());
                end
                if (out_kind == 2'd3) done = 1;
                got++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        chk(got == exp_k.size(), req, "word count", got, exp_k.size());
        chk(idx == NCH*NT, req, "samples taken", idx, NCH*NT);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_quiet();  // R9: only the end word
        clear_event();
        ev[1][5] = 10'sd20; ev[2][9] = -10'sd200;
        run_event("R9", 20, 100, 2, 2, 0, 0);
    endtask

    task automatic t_levels();  // R2: strict, signed comparisons
        clear_event();
        ev[1][10] = 10'sd50; ev[1][11] = 10'sd150; ev[1][12] = 10'sd60;
        ev[2][4]  = 10'sd40; ev[2][5]  = 10'sd50;
        ev[2][15] = 10'sd100;
        ev[3][8]  = 10'sd20; ev[3][20] = -10'sd300; ev[3][21] = 10'sd101;
        run_event("R2", 20, 100, 2, 2, 0, 0);
        // Header of the first cluster: ch1, start 8, length 7 (R5)
        chk(exp_d[0] == DW'((1 << 9) | (8 << 4) | 7), "R5", "model header", int'(exp_d[0]),
            (1 << 9) | (8 << 4) | 7);
    endtask

    task automatic t_edges();  // R3 clip at start, R7 close at end, no carry
        clear_event();
        ev[0][0]  = 10'sd200; ev[0][1] = 10'sd30;
        ev[2][31] = 10'sd300;
        ev[3][0]  = 10'sd40;  ev[3][1] = 10'sd45;
        ev[3][30] = 10'sd30;  ev[3][31] = 10'sd250;
        run_event("R7", 20, 100, 3, 3, 0, 0);
    endtask

    task automatic t_long();  // R8 forced close, R4 trailing guard claim, R3 free point
        clear_event();
        for (int t = 3; t < 12; t++) ev[1][t] = 10'sd50;
        ev[1][3] = 10'sd200;
        for (int t = 14; t < 22; t++) ev[2][t] = 10'sd60;
        ev[2][21] = 10'sd180;
        ev[0][5] = 10'sd120; ev[0][6] = 10'sd30; ev[0][7] = 10'sd130; ev[0][9] = 10'sd140;
        run_event("R8", 20, 100, 2, 2, 0, 0);
        run_event("R4", 20, 100, 3, 1, 0, 0);
    endtask

    task automatic t_noguard();  // R3/R4 with zero guard bands
        clear_event();
        ev[0][2] = 10'sd150; ev[0][3] = 10'sd40;
        ev[1][31] = 10'sd110; ev[2][0] = 10'sd120; ev[2][1] = 10'sd10;
        run_event("R3", 20, 100, 0, 0, 0, 0);
    endtask

    task automatic t_stress();  // R6, R10, R11 under gaps and back-pressure
        int s = 12345;
        clear_event();
        for (int c = 0; c < NCH; c++)
            for (int t = 0; t < NT; t++) begin
                s = s * 1103515245 + 12345;
                case ((s >>> 16) & 15)
                    0, 1:    ev[c][t] = SW'(((s >>> 8) & 255) - 40);
                    2:       ev[c][t] = -10'sd150;
                    3, 4:    ev[c][t] = 10'sd45;
                    default: ev[c][t] = SW'((s >>> 20) & 7);
                endcase
            end
        run_event("R6", 20, 100, 3, 2, 1, 1);
        run_event("R10", 20, 100, 1, 3, 1, 0);
        run_event("R11", 30, 60, 2, 1, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_quiet();
        t_levels();
        t_edges();
        t_long();
        t_noguard();
        t_stress();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule